// File: doc/BRIEF.md
# Single-Precision to BFloat16 Converter

This block narrows one IEEE-754 single-precision word to the 16-bit brain-float format: 1 sign bit, 8 exponent bits and 7 fraction bits. It behaves like the scalar narrowing convert of a floating-point unit. Rounding is always to nearest with ties to even. Subnormal operands go through the same rounding path and are never flushed to zero.

NaN operands are handled in one of two ways, chosen by a mode pin:
- **Payload mode:** the sign and the upper payload bits are kept, and the quiet bit is forced on.
- **Canonical mode:** every NaN becomes one fixed quiet NaN.

A signalling NaN raises an invalid-operation flag in either mode.

Operands arrive on a valid/ready handshake. The block never stalls. The result and the flag are registered and appear, together with an output valid, on the cycle after the operand is accepted.

Top module: `f2b_convert`

## Requirements
- R1: An operand accepted on a cycle (in_valid and in_ready high) gives out_valid high on the next cycle. A cycle with in_valid low gives out_valid low on the next cycle, and out_half keeps its previous value.
- R2: While rst_n is low, and after reset is released until the first accepted operand, out_valid and out_invalid are 0.
- R3: An operand is a NaN exactly when bits [30:0] are greater than 0x7F800000. The value 0x7F800000 itself is infinity, not a NaN.
- R4: When nan_canon is 0, a NaN operand gives operand bits [31:16] with result bit 6 forced to 1.
- R5: When nan_canon is 1, every NaN operand gives 0x7FC0.
- R6: out_invalid is 1 exactly when the operand is a NaN with bit 22 clear (a signalling NaN), in either NaN mode. Quiet NaNs and all non-NaN operands give 0.
- R7: For a non-NaN operand with bits [15:0] below 0x8000, the result is bits [31:16] unchanged.
- R8: For a non-NaN operand with bits [15:0] above 0x8000, the result is bits [31:16] plus 1.
- R9: For a non-NaN operand with bits [15:0] equal to 0x8000, the result is bits [31:16] plus bit 16, so ties round to even.
- R10: Positive zero gives 0x0000, negative zero 0x8000, positive infinity 0x7F80 and negative infinity 0xFF80.
- R11: Subnormal operands are rounded by the same rule and are not flushed. 0x00008001 gives 0x0001, and 0x007FFFFF gives 0x0080.
- R12: A carry out of the fraction during rounding moves into the exponent. 0x7F7FFFFF gives 0x7F80.
- R13: in_ready is always 1. The block accepts one operand per cycle with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand can be taken (always 1) |
| in_word | input | 32 | Single-precision operand |
| nan_canon | input | 1 | 1: all NaNs become 0x7FC0; 0: NaN payload is kept |
| out_valid | output | 1 | Result register holds a fresh result |
| out_half | output | 16 | BFloat16 result |
| out_invalid | output | 1 | Operand was a signalling NaN |

## Verification
The clocked properties assume the following about the inputs:
- in_word and nan_canon are known, not X, whenever in_valid is high.
- The mode pin is sampled on the same edge as the operand it applies to.
- Nothing downstream applies back-pressure.

The stimulus meets these assumptions. It changes every input only at the falling clock edge, holds in_valid for exactly one cycle per operand, and sets the mode together with the operand. It reads the result at the next falling edge.

// File: rtl/f2b_pkg.sv
package f2b_pkg;

    // Operand classes that the conversion datapath needs.
    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_inf;
        logic is_zero;
    } f2b_class_t;

endpackage

// File: rtl/f2b_classify.sv
module f2b_classify
    import f2b_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W-1:0] mag,
    output f2b_class_t             cls
);
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_ones;
    logic             exp_zero;
    logic             man_zero;

    always_comb begin
        exp_f    = mag[EXP_W+MAN_W-1:MAN_W];
        man_f    = mag[MAN_W-1:0];
        exp_ones = &exp_f;
        exp_zero = ~|exp_f;
        man_zero = ~|man_f;

        cls.is_nan  = exp_ones & ~man_zero;
        // Signalling: quiet bit (top fraction bit) clear, payload nonzero.
        cls.is_snan = exp_ones & ~man_zero & ~man_f[MAN_W-1];
        cls.is_inf  = exp_ones & man_zero;
        cls.is_zero = exp_zero & man_zero;
    end
endmodule

// File: rtl/f2b_round.sv
module f2b_round #(
    parameter int SRC_W  = 32,
    parameter int DST_W  = 16
) (
    input  logic [SRC_W-1:0] word,
    output logic [DST_W-1:0] rounded
);
    localparam int DROP_W = SRC_W - DST_W;

    logic [DST_W-1:0]  keep;
    logic [DROP_W-1:0] low;
    logic              guard;
    logic              sticky;
    logic              bump;

    always_comb begin
        keep   = word[SRC_W-1:DROP_W];
        low    = word[DROP_W-1:0];
        guard  = low[DROP_W-1];
        sticky = |low[DROP_W-2:0];
        // Above half: guard and sticky. Exact half: guard and odd lsb.
        bump    = guard & (sticky | keep[0]);
        // Plain add; a fraction carry ripples into the exponent field.
        rounded = keep + {{(DST_W-1){1'b0}}, bump};
    end
endmodule

// File: rtl/f2b_nan_shape.sv
module f2b_nan_shape #(
    parameter int EXP_W     = 8,
    parameter int DST_MAN_W = 7
) (
    input  logic [EXP_W+DST_MAN_W:0] upper,
    input  logic                     canon,
    output logic [EXP_W+DST_MAN_W:0] nan_half
);
    localparam int DST_W = 1 + EXP_W + DST_MAN_W;
    localparam logic [DST_W-1:0] QUIET_BIT = DST_W'(1) << (DST_MAN_W - 1);
    localparam logic [DST_W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(DST_MAN_W-1){1'b0}}};

    always_comb begin
        if (canon) nan_half = CANON_NAN;
        else       nan_half = upper | QUIET_BIT;
    end
endmodule

// File: rtl/f2b_convert.sv
module f2b_convert
    import f2b_pkg::*;
#(
    parameter int EXP_W     = 8,
    parameter int SRC_MAN_W = 23,
    parameter int DST_MAN_W = 7
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    output logic                           in_ready,
    input  logic [EXP_W+SRC_MAN_W:0]       in_word,
    input  logic                           nan_canon,
    output logic                           out_valid,
    output logic [EXP_W+DST_MAN_W:0]       out_half,
    output logic                           out_invalid
);
    localparam int SRC_W  = 1 + EXP_W + SRC_MAN_W;
    localparam int DST_W  = 1 + EXP_W + DST_MAN_W;
    localparam int DROP_W = SRC_W - DST_W;
    localparam logic [SRC_W-2:0] INF_MAG = {{EXP_W{1'b1}}, {SRC_MAN_W{1'b0}}};
    localparam logic [DST_W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(DST_MAN_W-1){1'b0}}};

    typedef struct packed {
        logic             valid;
        logic [DST_W-1:0] half;
        logic             invalid;
    } stage_t;

    stage_t           stage_d, stage_q;
    f2b_class_t       cls;
    logic [DST_W-1:0] rounded;
    logic [DST_W-1:0] nan_half;
    logic             accept;

    f2b_classify #(.EXP_W(EXP_W), .MAN_W(SRC_MAN_W)) u_class (
        .mag (in_word[SRC_W-2:0]),
        .cls (cls)
    );

    f2b_round #(.SRC_W(SRC_W), .DST_W(DST_W)) u_round (
        .word    (in_word),
        .rounded (rounded)
    );

    f2b_nan_shape #(.EXP_W(EXP_W), .DST_MAN_W(DST_MAN_W)) u_nan (
        .upper    (in_word[SRC_W-1:DROP_W]),
        .canon    (nan_canon),
        .nan_half (nan_half)
    );

    assign in_ready = 1'b1;
    assign accept   = in_valid & in_ready;

    always_comb begin
        stage_d         = stage_q;
        stage_d.valid   = accept;
        stage_d.invalid = accept & cls.is_snan;
        if (accept) stage_d.half = cls.is_nan ? nan_half : rounded;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign out_valid   = stage_q.valid;
    assign out_half    = stage_q.half;
    assign out_invalid = stage_q.invalid;

    // R1: an accepted operand yields a result on the following cycle.
    a_r1_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);
    // R1: an idle cycle yields no valid result and leaves the result unchanged.
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_half)));
    // R4: a NaN in payload mode leaves a quiet NaN with the same sign.
    a_r4_quiet_nan: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !nan_canon && in_word[SRC_W-2:0] > INF_MAG) |=>
        (&out_half[DST_W-2:DST_MAN_W-1]) && out_half[DST_W-1] == $past(in_word[SRC_W-1]));
    // R5: canonical NaN mode.
    a_r5_canon_nan: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && nan_canon && in_word[SRC_W-2:0] > INF_MAG) |=> out_half == CANON_NAN);
    // R6: the flag only ever accompanies a valid NaN result.
    a_r6_flag_nan_only: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> (out_valid && (&out_half[DST_W-2:DST_MAN_W-1])));
    // R10: infinities and zeros keep their sign and class.
    a_r10_inf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (cls.is_inf || cls.is_zero)) |=>
        out_half[DST_W-2:0] == ($past(cls.is_inf) ? {{EXP_W{1'b1}}, {DST_MAN_W{1'b0}}}
                                                  : {(DST_W-1){1'b0}}));
    // R12: finite operands never produce a result above infinity magnitude.
    a_r12_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_word[SRC_W-2:0] <= INF_MAG) |=>
        (out_half[DST_W-2:0] <= {{EXP_W{1'b1}}, {DST_MAN_W{1'b0}}} &&
         out_half[DST_W-1] == $past(in_word[SRC_W-1])));
    // R13: the block never stalls.
    a_r13_ready: assert property (@(posedge clk) disable iff (!rst_n) in_ready);
endmodule

// File: tb/f2b_convert_test.sv
`timescale 1ns/1ps
module f2b_convert_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_word;
    logic        nan_canon;
    logic        out_valid;
    logic [15:0] out_half;
    logic        out_invalid;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    f2b_convert uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .nan_canon(nan_canon), .out_valid(out_valid),
        .out_half(out_half), .out_invalid(out_invalid)
    );

    function automatic logic is_nan_op(input logic [31:0] w);
        return (w & 32'h7FFF_FFFF) > 32'h7F80_0000;
    endfunction

    function automatic logic [15:0] model_half(input logic [31:0] w, input logic canon);
        logic [32:0] sum;
        if (is_nan_op(w)) return canon ? 16'h7FC0 : (w[31:16] | 16'h0040);
        sum = {1'b0, w} + 33'h7FFF + {32'b0, w[16]};
        return sum[31:16];
    endfunction

    function automatic string model_tag(input logic [31:0] w, input logic canon);
        if (is_nan_op(w))            return canon ? "R5" : "R4";
        if (w[15:0] == 16'h8000)     return "R9";
        if (w[15:0] > 16'h8000)      return "R8";
        return "R7";
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic run(input logic [31:0] w, input logic canon, input string tag);
        @(negedge clk);
        in_valid  = 1'b1;
        in_word   = w;
        nan_canon = canon;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1", {31'b0, out_valid}, 32'd1);
        chk(tag, {16'b0, out_half}, {16'b0, model_half(w, canon)});
        chk("R6", {31'b0, out_invalid}, {31'b0, is_nan_op(w) & ~w[22]});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_word = '0; nan_canon = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2", {30'b0, out_valid, out_invalid}, 32'd0);
        chk("R13", {31'b0, in_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", {30'b0, out_valid, out_invalid}, 32'd0);

        run(32'h0000_0000, 1'b0, "R10");
        run(32'h8000_0000, 1'b0, "R10");
        run(32'h7F80_0000, 1'b0, "R10");
        run(32'hFF80_0000, 1'b1, "R10");
        run(32'h7F80_0001, 1'b0, "R3");
        run(32'h7F80_0001, 1'b1, "R5");
        run(32'hFFA0_0000, 1'b0, "R4");
        run(32'h7FC1_2345, 1'b0, "R4");
        run(32'hFFC0_0001, 1'b1, "R5");
        run(32'h3F80_8000, 1'b0, "R9");
        run(32'h3F81_8000, 1'b0, "R9");
        run(32'h3F80_7FFF, 1'b0, "R7");
        run(32'hBF80_8001, 1'b0, "R8");
        run(32'h0000_8001, 1'b0, "R11");
        run(32'h007F_FFFF, 1'b0, "R11");
        run(32'h0000_0001, 1'b0, "R11");
        run(32'h7F7F_FFFF, 1'b0, "R12");
        run(32'hFF7F_FFFF, 1'b0, "R12");
        chk("R12", {16'b0, out_half}, 32'h0000_FF80);

        // R1: idle cycle drops valid and holds the result.
        @(negedge clk);
        chk("R1", {31'b0, out_valid}, 32'd0);
        chk("R1", {16'b0, out_half}, 32'h0000_FF80);
        chk("R13", {31'b0, in_ready}, 32'd1);

        // Strided sweep across all exponents in both NaN modes.
        for (int m = 0; m < 2; m++) begin
            for (longint x = 64'hFFFF_0000; x >= 0; x -= (64'd1 << 20) + (64'd1 << 14)) begin
                run(x[31:0], m[0], model_tag(x[31:0], m[0]));
            end
        end
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog got=timeout exp=completion");
            finish_run();
        end
    end
endmodule